// File: doc/BRIEF.md
# Command and Interrupt Status Port

This block is the command and status port of a network controller's register file. A host writes 16-bit command words into it and reads a 16-bit status word back. Both sit at one fixed offset that every register window shares. Each command word holds a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. Using these commands, the host can:

- pick the active register window;
- switch the receiver and the transmitter on or off;
- pulse reset into either data path;
- program the interrupt mask, the read-zero mask and the receive address filter;
- raise or clear interrupt events;
- reset the whole controller.

Transmit and receive logic outside the block report events as one-cycle pulses. The block holds each event until the host acknowledges it. It keeps a summary latch bit set while any enabled event is pending, and drives an interrupt request from that latch. The status word also carries the current window number and a busy flag. The busy flag stays set for a programmable number of cycles after a global reset, and the block refuses all work during that time.

Top module: `cmdstat_unit`

## Requirements
- R1: After rst_n is released, the block is in its reset state. status_word is 16'h0000 (reserved bits 11:8 always read zero), and irq, rx_on, tx_on, rx_rst, tx_rst and rx_filter are all zero. The interrupt mask resets to all zeros and the read-zero mask resets to all ones.
- R2: A command takes effect on the rising edge where cmd_valid is high. Its opcode is cmd_word[15:11]:
  - 0 global reset
  - 1 window select
  - 3 RX off
  - 4 RX on
  - 5 RX reset
  - 9 TX on
  - 10 TX off
  - 11 TX reset
  - 12 request interrupt
  - 13 acknowledge
  - 14 interrupt mask
  - 15 read-zero mask
  - 16 RX filter

  Any other opcode, and any word presented with cmd_valid low, changes nothing.
- R3: Window select copies argument bits 2:0 into status bits 15:13. Argument bits 10:3 are ignored.
- R4: A high bit of evt_in sets the matching pending bit, which is visible in status one cycle later. The bits are 7 statistics update, 5 RX early, 4 RX complete, 3 TX available, 2 TX complete and 1 adapter failure. Bits 0 and 6 of evt_in are ignored.
- R5: Acknowledge clears each pending status bit whose position in argument bits 7:0 is set. An event pulse arriving in the same cycle as its acknowledge wins, and the bit stays set.
- R6: Request interrupt sets pending bit 6.
- R7: Status bit 0 (latch) is set in any cycle where a pending bit 7:1 is also set in the interrupt mask, using the mask value written that same cycle. Once set, it stays set until an acknowledge with argument bit 0 arrives while no enabled event is pending.
- R8: irq equals the latch bit ANDed with interrupt mask bit 0.
- R9: Status bits 7:1 show pending bits ANDed with the read-zero mask. Bit 0 is not masked. Hidden bits stay pending and can still be acknowledged.
- R10: RX filter loads argument bits 3:0 into rx_filter. The bits mean: bit 0 station address, bit 1 multicast, bit 2 broadcast, bit 3 accept all.
- R11: rx_on and tx_on are levels, set by the on commands and cleared by the off commands. The receiver is off after reset.
- R12: RX reset and TX reset each drive rx_rst or tx_rst high for exactly the one cycle after the command edge. They change no other state.
- R13: Global reset returns all state to its R1 values. Status bit 12 is then high for exactly RST_CYCLES cycles. While it is high, every command and event pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command: opcode 15:11, argument 10:0 |
| evt_in | input | 8 | One-cycle event pulses in status bit positions |
| status_word | output | 16 | Window, busy, masked pending bits, latch |
| irq | output | 1 | Interrupt request |
| rx_on | output | 1 | Receiver enabled level |
| tx_on | output | 1 | Transmitter enabled level |
| rx_rst | output | 1 | One-cycle receive path reset |
| tx_rst | output | 1 | One-cycle transmit path reset |
| rx_filter | output | 4 | Receive address filter selection |

## Verification
The bench aims at the points where several effects land on one edge:
- An acknowledge that collides with a new event of the same bit. A design that lets the clear win loses that event for good.
- A mask write that arrives in the same cycle as a pending event. A design that looks at the old mask sets the latch one cycle late or drops it.
- The busy window after a global reset, checked by counting its cycles and by sending a window change and an event into it. A design that is off by one, or that accepts work while busy, shows up in the window bits or the pending bits.
- Bits hidden by the read-zero mask must still be cleared by an acknowledge. Event bits 0 and 6 must not be settable from outside.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;

    localparam int CMD_W  = 16;
    localparam int OP_W   = 5;
    localparam int ARG_W  = CMD_W - OP_W;
    localparam int WIN_W  = 3;
    localparam int EVT_W  = 8;
    localparam int FILT_W = 4;
    localparam int RSV_W  = CMD_W - WIN_W - 1 - EVT_W;

    typedef enum logic [OP_W-1:0] {
        OP_GLB_RST = 5'd0,
        OP_WIN     = 5'd1,
        OP_RX_OFF  = 5'd3,
        OP_RX_ON   = 5'd4,
        OP_RX_RST  = 5'd5,
        OP_TX_ON   = 5'd9,
        OP_TX_OFF  = 5'd10,
        OP_TX_RST  = 5'd11,
        OP_REQ_INT = 5'd12,
        OP_ACK     = 5'd13,
        OP_IMASK   = 5'd14,
        OP_RZMASK  = 5'd15,
        OP_FILT    = 5'd16
    } op_e;

    // event positions that external pulses may set (bits 0 and 6 are internal)
    localparam logic [EVT_W-1:0] EVT_EXT_MASK = 8'hBE;
    localparam int BIT_REQ = 6;

    typedef struct packed {
        logic glb_rst;
        logic win;
        logic rx_off;
        logic rx_on;
        logic rx_rst;
        logic tx_on;
        logic tx_off;
        logic tx_rst;
        logic req_int;
        logic ack;
        logic imask;
        logic rzmask;
        logic filt;
        logic [ARG_W-1:0] arg;
    } act_t;

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [EVT_W-1:0]  imask;
        logic [EVT_W-1:0]  rzmask;
        logic [FILT_W-1:0] filt;
        logic              rx_on;
        logic              tx_on;
        logic              rx_rst;
        logic              tx_rst;
    } cfg_t;

    typedef struct packed {
        logic [EVT_W-1:1] pend;
        logic             latch;
    } evt_t;

endpackage

// File: rtl/cmdstat_decode.sv
module cmdstat_decode
    import cmdstat_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             busy,
    output act_t             act
);

    op_e  op;
    logic take;

    assign op   = op_e'(cmd_word[CMD_W-1 -: OP_W]);
    assign take = cmd_valid && !busy;

    always_comb begin
        act     = '0;
        act.arg = cmd_word[ARG_W-1:0];
        if (take) begin
            case (op)
                OP_GLB_RST: act.glb_rst = 1'b1;
                OP_WIN:     act.win     = 1'b1;
                OP_RX_OFF:  act.rx_off  = 1'b1;
                OP_RX_ON:   act.rx_on   = 1'b1;
                OP_RX_RST:  act.rx_rst  = 1'b1;
                OP_TX_ON:   act.tx_on   = 1'b1;
                OP_TX_OFF:  act.tx_off  = 1'b1;
                OP_TX_RST:  act.tx_rst  = 1'b1;
                OP_REQ_INT: act.req_int = 1'b1;
                OP_ACK:     act.ack     = 1'b1;
                OP_IMASK:   act.imask   = 1'b1;
                OP_RZMASK:  act.rzmask  = 1'b1;
                OP_FILT:    act.filt    = 1'b1;
                default:    act.arg     = cmd_word[ARG_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/cmdstat_busy.sv
module cmdstat_busy #(
    parameter int RST_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(RST_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/cmdstat_cfg.sv
module cmdstat_cfg
    import cmdstat_pkg::*;
#(
    parameter logic [EVT_W-1:0] RZMASK_RST = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_t             act,
    output cfg_t             cfg,
    output logic [EVT_W-1:0] imask_nxt
);

    localparam cfg_t CFG_RST = '{
        win:    '0,
        imask:  '0,
        rzmask: RZMASK_RST,
        filt:   '0,
        rx_on:  1'b0,
        tx_on:  1'b0,
        rx_rst: 1'b0,
        tx_rst: 1'b0
    };

    cfg_t cfg_d, cfg_q;
    logic unused_arg_hi;

    assign unused_arg_hi = ^act.arg[ARG_W-1:EVT_W];

    always_comb begin
        cfg_d        = cfg_q;
        cfg_d.rx_rst = 1'b0;
        cfg_d.tx_rst = 1'b0;
        if (act.glb_rst) begin
            cfg_d = CFG_RST;
        end else begin
            if (act.win)    cfg_d.win    = act.arg[WIN_W-1:0];
            if (act.imask)  cfg_d.imask  = act.arg[EVT_W-1:0];
            if (act.rzmask) cfg_d.rzmask = act.arg[EVT_W-1:0];
            if (act.filt)   cfg_d.filt   = act.arg[FILT_W-1:0];
            if (act.rx_on)  cfg_d.rx_on  = 1'b1;
            if (act.rx_off) cfg_d.rx_on  = 1'b0;
            if (act.tx_on)  cfg_d.tx_on  = 1'b1;
            if (act.tx_off) cfg_d.tx_on  = 1'b0;
            if (act.rx_rst) cfg_d.rx_rst = 1'b1;
            if (act.tx_rst) cfg_d.tx_rst = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg       = cfg_q;
    assign imask_nxt = cfg_d.imask;

endmodule

// File: rtl/cmdstat_events.sv
module cmdstat_events
    import cmdstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  act_t             act,
    input  logic             busy,
    input  logic [EVT_W-1:0] evt_in,
    input  logic [EVT_W-1:0] imask_nxt,
    output evt_t             evt
);

    evt_t             evt_d, evt_q;
    logic [EVT_W-1:0] set_v;
    logic [EVT_W-1:0] clr_v;
    logic             latch_hold;
    logic             unused_mask0;

    assign unused_mask0 = imask_nxt[0];

    always_comb begin
        set_v = busy ? '0 : (evt_in & EVT_EXT_MASK);
        set_v[BIT_REQ] = act.req_int;
        clr_v = act.ack ? act.arg[EVT_W-1:0] : '0;
        latch_hold = evt_q.latch && !clr_v[0];

        evt_d = evt_q;
        if (act.glb_rst) begin
            evt_d = '0;
        end else begin
            // a fresh event outranks its own acknowledge
            evt_d.pend  = (evt_q.pend & ~clr_v[EVT_W-1:1]) | set_v[EVT_W-1:1];
            evt_d.latch = (|(evt_d.pend & imask_nxt[EVT_W-1:1])) || latch_hold;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign evt = evt_q;

endmodule

// File: rtl/cmdstat_unit.sv
module cmdstat_unit
    import cmdstat_pkg::*;
#(
    parameter int RST_CYCLES = 50000,
    parameter logic [7:0] RZMASK_RST = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic [7:0]  evt_in,
    output logic [15:0] status_word,
    output logic        irq,
    output logic        rx_on,
    output logic        tx_on,
    output logic        rx_rst,
    output logic        tx_rst,
    output logic [3:0]  rx_filter
);

    act_t             act;
    cfg_t             cfg;
    evt_t             evt;
    logic             busy;
    logic [EVT_W-1:0] imask_nxt;

    cmdstat_decode i_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .busy      (busy),
        .act       (act)
    );

    cmdstat_busy #(
        .RST_CYCLES (RST_CYCLES)
    ) i_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (act.glb_rst),
        .busy  (busy)
    );

    cmdstat_cfg #(
        .RZMASK_RST (RZMASK_RST)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .cfg       (cfg),
        .imask_nxt (imask_nxt)
    );

    cmdstat_events i_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .busy      (busy),
        .evt_in    (evt_in),
        .imask_nxt (imask_nxt),
        .evt       (evt)
    );

    assign status_word = {cfg.win,
                          busy,
                          {RSV_W{1'b0}},
                          evt.pend & cfg.rzmask[EVT_W-1:1],
                          evt.latch};
    assign irq       = evt.latch & cfg.imask[0];
    assign rx_on     = cfg.rx_on;
    assign tx_on     = cfg.tx_on;
    assign rx_rst    = cfg.rx_rst;
    assign tx_rst    = cfg.tx_rst;
    assign rx_filter = cfg.filt;

endmodule

// File: rtl/cmdstat_chk.sv
module cmdstat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [7:0]  evt_in,
    input logic [15:0] status_word,
    input logic        irq,
    input logic        rx_on,
    input logic        rx_rst,
    input logic        tx_rst
);

    logic busy;
    logic [4:0] op;

    assign busy = status_word[12];
    assign op   = cmd_word[15:11];

    AST_BUSY_HOLDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(status_word[15:13])); // R13

    AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && op == 5'd13 && cmd_word[4] && !evt_in[4]) |=> !status_word[4]); // R5

    AST_IRQ_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status_word[0]); // R8

    AST_RX_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && op == 5'd4) |=> rx_on); // R11

    AST_RX_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |-> $past(cmd_valid && !busy && op == 5'd5)); // R12

    AST_TX_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |-> $past(cmd_valid && !busy && op == 5'd11)); // R12

endmodule

bind cmdstat_unit cmdstat_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .evt_in      (evt_in),
    .status_word (status_word),
    .irq         (irq),
    .rx_on       (rx_on),
    .rx_rst      (rx_rst),
    .tx_rst      (tx_rst)
);

// File: tb/test_cmdstat_unit.sv
module test_cmdstat_unit;

    localparam int BUSY_N = 24;
    localparam int NVEC   = 20;
    localparam int WD_MAX = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  evt_in = '0;
    logic [15:0] status_word;
    logic        irq, rx_on, tx_on, rx_rst, tx_rst;
    logic [3:0]  rx_filter;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmdstat_unit #(.RST_CYCLES(BUSY_N)) i_cmdstat_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .evt_in(evt_in), .status_word(status_word), .irq(irq), .rx_on(rx_on),
        .tx_on(tx_on), .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_filter(rx_filter)
    );

    // {valid, cmd, evt, expected status, expected irq}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1, 16'h0805, 8'h00, 16'hA000, 1'b0}, // 0  R3 window 5
        {1'b1, 16'h70FF, 8'h00, 16'hA000, 1'b0}, // 1  R7 mask all
        {1'b1, 16'hF800, 8'h04, 16'hA005, 1'b1}, // 2  R4 R7 R8 tx complete
        {1'b1, 16'h6804, 8'h00, 16'hA001, 1'b1}, // 3  R5 latch held
        {1'b1, 16'h6801, 8'h00, 16'hA000, 1'b0}, // 4  R7 latch ack
        {1'b1, 16'h7001, 8'h00, 16'hA000, 1'b0}, // 5  mask only bit 0
        {1'b1, 16'hF800, 8'h10, 16'hA010, 1'b0}, // 6  R4 R7 masked event
        {1'b1, 16'h6000, 8'h00, 16'hA050, 1'b0}, // 7  R6 request
        {1'b1, 16'h7840, 8'h00, 16'hA040, 1'b0}, // 8  R9 read-zero
        {1'b1, 16'h7041, 8'h00, 16'hA041, 1'b1}, // 9  R7 R8 same-cycle mask
        {1'b1, 16'h7040, 8'h00, 16'hA041, 1'b0}, // 10 R8 irq gate
        {1'b0, 16'h68FF, 8'h00, 16'hA041, 1'b0}, // 11 R2 not valid
        {1'b1, 16'h68FF, 8'h00, 16'hA000, 1'b0}, // 12 R5 ack all
        {1'b1, 16'h78FF, 8'h00, 16'hA000, 1'b0}, // 13 R9 hidden bit cleared
        {1'b1, 16'h6810, 8'h10, 16'hA010, 1'b0}, // 14 R5 event wins
        {1'b1, 16'h3FFF, 8'h00, 16'hA010, 1'b0}, // 15 R2 undefined opcode
        {1'b1, 16'h68FF, 8'h00, 16'hA000, 1'b0}, // 16 R5
        {1'b1, 16'hF800, 8'h41, 16'hA000, 1'b0}, // 17 R4 bits 0,6 ignored
        {1'b1, 16'h0FFA, 8'h80, 16'h4080, 1'b0}, // 18 R3 R4 upper arg ignored
        {1'b1, 16'h68FF, 8'h00, 16'h4000, 1'b0}  // 19 R5
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [15:0] c, input logic [7:0] e);
        cmd_valid = v;
        cmd_word  = c;
        evt_in    = e;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
        evt_in    = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", 32'(status_word), 32'h0000);
        check("R1 irq", 32'(irq), 0);
        check("R1 rx_on", 32'(rx_on), 0);
        check("R1 tx_on", 32'(tx_on), 0);
        check("R1 pulses", 32'({rx_rst, tx_rst}), 0);
        check("R1 filter", 32'(rx_filter), 0);
        apply(1'b1, 16'hF800, 8'h02);
        check("R1 read-zero mask ones, imask zero", 32'({status_word, irq}), {15'd0, 16'h0002, 1'b0});
        apply(1'b1, 16'h68FF, 8'h00);
        check("R1 cleared", 32'(status_word), 32'h0000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][41], VEC[i][40:25], VEC[i][24:17]);
            check($sformatf("vector %0d status", i), 32'(status_word), 32'(VEC[i][16:1]));
            check($sformatf("vector %0d irq", i), 32'(irq), 32'(VEC[i][0]));
        end

        // R10 filter
        apply(1'b1, 16'h800D, 8'h00);
        check("R10 filter", 32'(rx_filter), 32'hD);
        apply(1'b1, 16'h87F5, 8'h00);
        check("R10 filter upper arg", 32'(rx_filter), 32'h5);

        // R11 enable levels
        apply(1'b1, 16'h2000, 8'h00);
        check("R11 rx on", 32'({rx_on, tx_on}), 32'b10);
        apply(1'b1, 16'h4800, 8'h00);
        check("R11 tx on", 32'({rx_on, tx_on}), 32'b11);
        apply(1'b1, 16'h1800, 8'h00);
        check("R11 rx off", 32'({rx_on, tx_on}), 32'b01);
        apply(1'b1, 16'h5000, 8'h00);
        check("R11 tx off", 32'({rx_on, tx_on}), 32'b00);

        // R12 reset pulses
        apply(1'b1, 16'h2800, 8'h00);
        check("R12 rx pulse", 32'({rx_rst, tx_rst}), 32'b10);
        @(posedge clk); @(negedge clk);
        check("R12 rx pulse ends", 32'({rx_rst, tx_rst}), 32'b00);
        apply(1'b1, 16'h5800, 8'h00);
        check("R12 tx pulse", 32'({rx_rst, tx_rst, rx_on, tx_on}), 32'b0100);
        @(posedge clk); @(negedge clk);
        check("R12 tx pulse ends", 32'({rx_rst, tx_rst}), 32'b00);

        // R13 global reset
        apply(1'b1, 16'h0803, 8'h00);
        apply(1'b1, 16'h4800, 8'h00);
        apply(1'b1, 16'h0000, 8'h00);
        check("R13 busy, state reset", 32'({status_word, tx_on}), {15'd0, 16'h1000, 1'b0});
        seen = 1;
        apply(1'b1, 16'h0806, 8'h04);
        check("R13 ignored while busy", 32'(status_word), 32'h1000);
        if (status_word[12]) seen++;
        for (int k = 0; k < 4 * BUSY_N && status_word[12]; k++) begin
            @(posedge clk); @(negedge clk);
            if (status_word[12]) seen++;
        end
        check("R13 busy length", 32'(seen), 32'(BUSY_N));
        apply(1'b1, 16'h0805, 8'h02);
        check("R13 accepted after busy", 32'({status_word, irq}), {15'd0, 16'hA002, 1'b0});

        finish_run();
    end

endmodule